// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit

This unit is the multiply-accumulate slice of a 64-bit integer execution pipeline. It takes the current value of the destination register as its accumulator, multiplies the two source operands, and either adds the product to the accumulator or subtracts it. The sum always wraps silently. Three operand widths are supported:
- full 64-bit operands with a 64-bit result;
- a word form whose wrapped 32-bit result is sign-extended to 64 bits;
- a halfword form that multiplies the sign-extended low 16 bits of each source and sign-extends the 32-bit result.

Operations enter through a valid/ready handshake. `in_ready` is high only when no operation is in flight, so an operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result comes back a fixed two cycles later, marked by a one-cycle `out_done` pulse. The result interface has no back-pressure, so the consumer must take the result in the `out_done` cycle. `out_result` then holds its value until the next `out_done`. Register forwarding and hazard handling belong to the surrounding pipeline.

Top module: `mac_unit`

## Requirements
- R1: With `in_op[2:1]` = 0 (full width) and `in_op[0]` = 0, the result is `in_rd + in_rs1 * in_rs2` modulo 2^64, with no overflow indication.
- R2: With `in_op[2:1]` = 0 and `in_op[0]` = 1, the result is `in_rd - in_rs1 * in_rs2` modulo 2^64.
- R3: With `in_op[2:1]` = 1 (word), the full-width add or subtract selected by `in_op[0]` is formed, and its bit 31 is copied into bits 63:32 of the result.
- R4: With `in_op[2:1]` = 2 (halfword), bits 15:0 of each source are sign-extended before the multiply. Bits 63:16 of the sources have no effect. The product is added to or subtracted from `in_rd`, and bit 31 of the sum is copied into bits 63:32.
- R5: The width code `in_op[2:1]` = 3 behaves exactly as full width (R1/R2).
- R6: An operation accepted on rising edge k raises `out_done` for exactly the one cycle that follows edge k+2, with the matching `out_result`.
- R7: `in_ready` is low from the edge that accepts an operation until `out_done` has fallen. `in_valid` presented while `in_ready` is low is ignored: it produces no extra `out_done` and does not change any result. `busy` is high exactly while `in_ready` is low outside reset.
- R8: `out_result` keeps its value in every cycle where `out_done` is low.
- R9: While `rst_n` is low: `in_ready` = 0, `busy` = 0, `out_done` = 0, `out_result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request |
| in_ready | output | 1 | Unit idle; request accepted when both are high |
| in_op | input | 3 | Bit 0: subtract; bits 2:1: width (0 full, 1 word, 2 halfword, 3 full) |
| in_rs1 | input | 64 | First multiplicand |
| in_rs2 | input | 64 | Second multiplicand |
| in_rd | input | 64 | Accumulator, the old destination value |
| out_done | output | 1 | One-cycle result strobe |
| out_result | output | 64 | Result, held between strobes |
| busy | output | 1 | An operation is in flight |

## Verification
The bench targets three groups of corner cases.

- **Sign extension at the narrow widths.** It uses word operations whose 64-bit sum has bit 31 set while the upper bits are clear. It also uses halfword operations with negative low halves and random upper bits in the sources. A design that zero-extends, or that reads the upper source bits, returns the wrong upper result word.
- **Wrap-around.** Full-width products and sums deliberately cross 2^64, and subtraction is driven below zero. A unit that saturates or mixes up the operand order fails here.
- **Handshake.** `in_valid` is held high through the busy and done cycles. A unit that accepts requests early would produce extra strobes or overwrite a pending result. Width code 3 is also driven, to catch decoders that treat it as a narrow form.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [1:0] {
    MW_FULL = 2'd0,
    MW_WORD = 2'd1,
    MW_HALF = 2'd2,
    MW_ALT  = 2'd3
  } mac_width_e;

  typedef struct packed {
    mac_width_e width;
    logic       sub;
  } mac_op_t;

  function automatic mac_op_t decode_op(input logic [2:0] raw);
    mac_op_t o;
    o.sub   = raw[0];
    o.width = mac_width_e'(raw[2:1]);
    return o;
  endfunction

  function automatic logic is_narrow(input mac_width_e w);
    return (w == MW_WORD) || (w == MW_HALF);
  endfunction

endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep
  import mac_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HLEN = 16
) (
  input  mac_width_e        width,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  output logic [XLEN-1:0]   opnd_a,
  output logic [XLEN-1:0]   opnd_b
);
  localparam int EXT = XLEN - HLEN;

  logic [XLEN-1:0] half_a, half_b;

  assign half_a = {{EXT{src_a[HLEN-1]}}, src_a[HLEN-1:0]};
  assign half_b = {{EXT{src_b[HLEN-1]}}, src_b[HLEN-1:0]};

  always_comb begin
    if (width == MW_HALF) begin
      opnd_a = half_a;
      opnd_b = half_b;
    end else begin
      opnd_a = src_a;
      opnd_b = src_b;
    end
  end
endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
  import mac_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  mac_op_t         op_in,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] acc_in,
  output logic            s1_valid,
  output mac_op_t         s1_op,
  output logic [XLEN-1:0] s1_prod,
  output logic [XLEN-1:0] s1_acc
);
  localparam int UPPER = XLEN - WLEN + 1;

  logic [XLEN-1:0] prod_c;
  assign prod_c = opnd_a * opnd_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= '0;
      s1_prod  <= '0;
      s1_acc   <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_op   <= op_in;
        s1_prod <= prod_c;
        s1_acc  <= acc_in;
      end
    end
  end

  // R4
  half_prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_op.width == MW_HALF) |->
      (s1_prod[XLEN-1:WLEN-1] == {UPPER{1'b0}} || s1_prod[XLEN-1:WLEN-1] == {UPPER{1'b1}}));
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_valid,
  input  mac_op_t         s1_op,
  input  logic [XLEN-1:0] s1_prod,
  input  logic [XLEN-1:0] s1_acc,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int EXT = XLEN - WLEN;

  logic [XLEN-1:0] sum_c, res_c;
  logic            narrow_q;

  assign sum_c = s1_op.sub ? (s1_acc - s1_prod) : (s1_acc + s1_prod);

  always_comb begin
    if (is_narrow(s1_op.width)) res_c = {{EXT{sum_c[WLEN-1]}}, sum_c[WLEN-1:0]};
    else                         res_c = sum_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      result   <= '0;
      narrow_q <= 1'b0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        result   <= res_c;
        narrow_q <= is_narrow(s1_op.width);
      end
    end
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R3
  narrow_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && narrow_q) |-> (result[XLEN-1:WLEN] == {EXT{result[WLEN-1]}}));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  parameter int HLEN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_op,
  input  logic [XLEN-1:0] in_rs1,
  input  logic [XLEN-1:0] in_rs2,
  input  logic [XLEN-1:0] in_rd,
  output logic            out_done,
  output logic [XLEN-1:0] out_result,
  output logic            busy
);
  mac_op_t         op_d, s1_op;
  logic [XLEN-1:0] opnd_a, opnd_b, s1_prod, s1_acc;
  logic            s1_valid, take;

  assign op_d     = decode_op(in_op);
  assign busy     = s1_valid | out_done;
  assign in_ready = rst_n & ~busy;
  assign take     = in_valid & in_ready;

  mac_operand_prep #(.XLEN(XLEN), .HLEN(HLEN)) u_prep (
    .width  (op_d.width),
    .src_a  (in_rs1),
    .src_b  (in_rs2),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b)
  );

  mac_mul_stage #(.XLEN(XLEN), .WLEN(WLEN)) u_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .op_in    (op_d),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .acc_in   (in_rd),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_prod  (s1_prod),
    .s1_acc   (s1_acc)
  );

  mac_acc_stage #(.XLEN(XLEN), .WLEN(WLEN)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_op    (s1_op),
    .s1_prod  (s1_prod),
    .s1_acc   (s1_acc),
    .done     (out_done),
    .result   (out_result)
  );

  // R6
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_ready, 2) |-> out_done);

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && busy));

  // R7
  no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !in_ready);
endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [63:0] in_rs1 = '0, in_rs2 = '0, in_rd = '0;
  logic        out_done;
  logic [63:0] out_result;
  logic        busy;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // model state: 0 idle, 1 first stage, 2 done cycle
  int          m_phase = 0;
  logic [63:0] m_pend = '0, m_res = '0;
  string       m_pend_tag = "R1", m_res_tag = "R9";

  always #10 clk = ~clk;

  mac_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd),
    .out_done(out_done), .out_result(out_result), .busy(busy)
  );

  function automatic logic [63:0] ref_mac(input logic [2:0] op,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    longint signed x, y;
    logic [63:0] p, s;
    if (op[2:1] == 2'd2) begin
      x = longint'(shortint'(a[15:0]));
      y = longint'(shortint'(b[15:0]));
    end else begin
      x = a;
      y = b;
    end
    p = x * y;
    s = op[0] ? d - p : d + p;
    if (op[2:1] == 2'd1 || op[2:1] == 2'd2) s = longint'(int'(s[31:0]));
    return s;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op[2:1])
      2'd1: return "R3";
      2'd2: return "R4";
      2'd3: return "R5";
      default: return op[0] ? "R2" : "R1";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: compare at negedge, drive, advance model to next posedge
  task automatic cycle(input logic v, input logic [2:0] op,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    @(negedge clk);
    check("R7", "in_ready", 64'(in_ready), 64'(m_phase == 0));
    check("R7", "busy", 64'(busy), 64'(m_phase != 0));
    check("R6", "out_done", 64'(out_done), 64'(m_phase == 2));
    check(m_phase == 2 ? m_res_tag : "R8", "out_result", out_result, m_res);
    in_valid = v; in_op = op; in_rs1 = a; in_rs2 = b; in_rd = d;
    case (m_phase)
      0: if (v) begin
           m_pend = ref_mac(op, a, b, d);
           m_pend_tag = tag_of(op);
           m_phase = 1;
         end
      1: begin m_res = m_pend; m_res_tag = m_pend_tag; m_phase = 2; end
      default: m_phase = 0;
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] d);
    cycle(1'b1, op, a, b, d);
    cycle(1'b0, 3'd0, '0, '0, '0);
    cycle(1'b0, 3'd0, '0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R6 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    in_op = 3'd0;
    repeat (3) @(negedge clk);
    // R9 reset state, even with a request pending
    check("R9", "in_ready in reset", 64'(in_ready), 64'd0);
    check("R9", "busy in reset", 64'(busy), 64'd0);
    check("R9", "out_done in reset", 64'(out_done), 64'd0);
    check("R9", "out_result in reset", out_result, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;

    // R1 full add, plain and wrapping
    run_op(3'b000, 64'd7, 64'd6, 64'd100);
    run_op(3'b000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 64'd5);
    run_op(3'b000, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFF0);
    // R2 full subtract, below zero
    run_op(3'b001, 64'd3, 64'd4, 64'd10);
    run_op(3'b001, 64'h1234_5678_9ABC_DEF0, 64'd16, 64'd0);
    // R3 word: bit 31 set, upper bits clear
    run_op(3'b010, 64'd0, 64'd0, 64'h0000_0000_8000_0000);
    run_op(3'b010, 64'h0000_0001_0000_0000, 64'd3, 64'h0000_0005_7FFF_FFFF);
    run_op(3'b011, 64'd1, 64'd1, 64'd0);
    // R4 halfword with negative halves and junk upper bits
    run_op(3'b100, 64'hDEAD_BEEF_CAFE_FFFF, 64'h1234_5678_9ABC_0002, 64'd10);
    run_op(3'b101, 64'hFFFF_FFFF_FFFF_8000, 64'h0000_0000_0000_8000, 64'h0000_0000_4000_0000);
    run_op(3'b100, 64'h5555_0000_0000_7FFF, 64'hAAAA_0000_0000_7FFF, 64'hFFFF_FFFF_0000_0000);
    // R5 width code 3 is full width
    run_op(3'b110, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0003, 64'd1);
    run_op(3'b111, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0003, 64'd1);
    // R7 requests held through busy and done cycles are ignored
    cycle(1'b1, 3'b000, 64'd2, 64'd3, 64'd4);
    cycle(1'b1, 3'b001, 64'd9, 64'd9, 64'd9);
    cycle(1'b1, 3'b010, 64'd8, 64'd8, 64'd8);
    cycle(1'b1, 3'b100, 64'd5, 64'd5, 64'd1);
    cycle(1'b0, 3'd0, '0, '0, '0);
    cycle(1'b0, 3'd0, '0, '0, '0);
    // R8 result held over idle cycles
    repeat (4) cycle(1'b0, 3'd0, '0, '0, '0);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      cycle(1'($urandom_range(0, 2) != 0), 3'($urandom),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (3) cycle(1'b0, 3'd0, '0, '0, '0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule